// File: doc/BRIEF.md
# Serial Clock Synthesizer Programming Master

This block sits on the host side of a board-level clock synthesizer that takes its settings over a three-wire serial link: a serial clock, a data line and a commit strobe. Logic elsewhere in the chip presents a configuration record and pulses `start`. The record holds a crystal load-capacitance code, a duty-cycle select bit, a secondary-output function code, an output-divide select, a 9-bit VCO divider word and a 7-bit reference divider word. The block checks the divider words against the values the synthesizer forbids, then packs the record into a 24-bit frame and shifts it out most significant bit first. Once the last bit is in, it raises the strobe to commit the frame.

All serial timing comes from the system clock through cycle-count parameters. These set the data setup before each rising serial clock edge, the high time of the serial clock, the data hold after each falling edge, the gap before the strobe, and the strobe width. `busy` is high for the whole transfer. `err` reports a record that was refused.

Top module: `clksynth_prog_master`

## Requirements
- R1: The frame is sent most significant bit first as, in order: cap_code[1], cap_code[0], duty_sel, aux_func[1], aux_func[0], odiv_sel[2:0], vco_word[8:0], ref_word[6:0]. The record cap=0, duty=1, aux=2, odiv=1, vco=276, ref=59 therefore produces the bytes 00110001, 10001010, 00111011 (0x318A3B).
- R2: For each bit, `sdata` takes the bit value while `sclk` is low for SETUP_CYC cycles. `sclk` is then high for HIGH_CYC cycles and low again for HOLD_CYC cycles before `sdata` may change. An accepted record produces exactly 24 rising `sclk` edges.
- R3: `strobe` stays low while bits are shifted. It rises HOLD_CYC+GAP_CYC cycles after the last falling `sclk` edge and stays high for STB_CYC cycles, once per accepted record.
- R4: `busy` rises the cycle after an accepted `start` and falls in the same cycle as `strobe`. It is high for 24*(SETUP_CYC+HIGH_CYC+HOLD_CYC)+GAP_CYC+STB_CYC cycles in total.
- R5: A record with vco_word below 4 is refused. `err` goes high the cycle after `start`, and no `sclk` edge and no `strobe` follow.
- R6: A record with ref_word of 0 is refused as in R5 unless `bypass_req` is high. With `bypass_req` high it is sent like any other valid record.
- R7: `err` holds its value until the next `start` taken while idle, which clears it if the record is accepted.
- R8: A `start` that arrives while `busy` is high is ignored. This includes the final strobe cycle. No second frame follows.
- R9: During and after reset, `sclk`, `sdata`, `strobe`, `busy` and `err` are low, and they stay low until a `start` arrives. `sdata` returns low when a transfer ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to program the record |
| bypass_req | input | 1 | Allows a reference word of 0 (bypass) |
| cap_code | input | 2 | Crystal load-capacitance code |
| duty_sel | input | 1 | Duty-cycle threshold select |
| aux_func | input | 2 | Secondary output function code |
| odiv_sel | input | 3 | Output divide select |
| vco_word | input | 9 | VCO divider word (4..511) |
| ref_word | input | 7 | Reference divider word (1..127, 0 only for bypass) |
| sclk | output | 1 | Generated serial clock |
| sdata | output | 1 | Serial data, MSB first |
| strobe | output | 1 | Commit pulse after the last bit |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last idle start carried a refused record |

## Verification
Two events can land on the same cycle: the end of a strobe pulse and a new `start` request. The bench holds `start` high, with a different valid record, over every cycle of the first strobe pulse, including the last one where `busy` falls. It then judges the result at the pins. `busy` must go low and stay low, and no further `sclk` edge or `strobe` may appear. The vector table also lets a refused record and the clearing of its `err` by a later valid record occur on the same acceptance edge.

// File: rtl/clkprog_pkg.sv
package clkprog_pkg;

    // Field order here is the on-wire order, MSB sent first.
    typedef struct packed {
        logic [1:0] cap;
        logic       duty;
        logic [1:0] aux;
        logic [2:0] odiv;
        logic [8:0] vco;
        logic [6:0] refd;
    } clk_rec_t;

    localparam int FRAME_W = $bits(clk_rec_t);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_HOLD,
        PH_GAP,
        PH_STB
    } phase_e;

endpackage

// File: rtl/clkprog_check.sv
module clkprog_check
    import clkprog_pkg::*;
#(
    parameter int VCO_MIN = 4
) (
    input  clk_rec_t                 rec,
    input  logic                     bypass_req,
    output logic [FRAME_W-1:0]       frame,
    output logic                     rec_ok
);
    logic vco_bad;
    logic ref_bad;

    always_comb begin
        vco_bad = (int'(rec.vco) < VCO_MIN);
        ref_bad = (rec.refd == '0) && !bypass_req;
        rec_ok  = !vco_bad && !ref_bad;
        frame   = rec;
    end
endmodule

// File: rtl/clkprog_seq.sv
module clkprog_seq
    import clkprog_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 2,
    parameter int HOLD_CYC  = 1,
    parameter int GAP_CYC   = 1,
    parameter int STB_CYC   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rec_ok,
    input  logic [FRAME_W-1:0] frame,
    output logic               sclk,
    output logic               sdata,
    output logic               strobe,
    output logic               busy,
    output logic               err
);
    localparam int MAX_A = (SETUP_CYC > HIGH_CYC) ? SETUP_CYC : HIGH_CYC;
    localparam int MAX_B = (HOLD_CYC > GAP_CYC) ? HOLD_CYC : GAP_CYC;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXC  = (MAX_C > STB_CYC) ? MAX_C : STB_CYC;
    localparam int CW    = $clog2(MAXC + 1);
    localparam int BW    = $clog2(FRAME_W);

    typedef struct packed {
        phase_e             ph;
        logic [CW-1:0]      cnt;
        logic [BW-1:0]      bidx;
        logic [FRAME_W-1:0] shreg;
        logic               sclk;
        logic               data;
        logic               stb;
        logic               err;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (rec_ok) begin
                        s_d.ph    = PH_SETUP;
                        s_d.cnt   = '0;
                        s_d.bidx  = '0;
                        s_d.shreg = frame;
                        s_d.data  = frame[FRAME_W-1];
                        s_d.err   = 1'b0;
                    end else begin
                        s_d.err   = 1'b1;
                    end
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == CW'(SETUP_CYC - 1)) begin
                    s_d.ph   = PH_HIGH;
                    s_d.cnt  = '0;
                    s_d.sclk = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_HIGH: begin
                if (s_q.cnt == CW'(HIGH_CYC - 1)) begin
                    s_d.ph   = PH_HOLD;
                    s_d.cnt  = '0;
                    s_d.sclk = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == CW'(HOLD_CYC - 1)) begin
                    s_d.cnt = '0;
                    if (s_q.bidx == BW'(FRAME_W - 1)) begin
                        s_d.ph = PH_GAP;
                    end else begin
                        s_d.ph    = PH_SETUP;
                        s_d.bidx  = s_q.bidx + 1'b1;
                        s_d.shreg = s_q.shreg << 1;
                        s_d.data  = s_q.shreg[FRAME_W-2];
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_GAP: begin
                if (s_q.cnt == CW'(GAP_CYC - 1)) begin
                    s_d.ph  = PH_STB;
                    s_d.cnt = '0;
                    s_d.stb = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            PH_STB: begin
                if (s_q.cnt == CW'(STB_CYC - 1)) begin
                    s_d.ph   = PH_IDLE;
                    s_d.cnt  = '0;
                    s_d.stb  = 1'b0;
                    s_d.data = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk   = s_q.sclk;
    assign sdata  = s_q.data;
    assign strobe = s_q.stb;
    assign busy   = (s_q.ph != PH_IDLE);
    assign err    = s_q.err;

    // R3
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stb |-> !s_q.sclk);

    // R2
    data_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.sclk) |-> $stable(s_q.data));

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.sclk) |-> $stable(s_q.data));

    // R4
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stb |-> busy);

    // R5
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |-> !s_q.sclk && !s_q.stb);

    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> !$rose(s_q.err));
endmodule

// File: rtl/clksynth_prog_master.sv
module clksynth_prog_master
    import clkprog_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int HIGH_CYC  = 2,
    parameter int HOLD_CYC  = 1,
    parameter int GAP_CYC   = 1,
    parameter int STB_CYC   = 4,
    parameter int VCO_MIN   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       bypass_req,
    input  logic [1:0] cap_code,
    input  logic       duty_sel,
    input  logic [1:0] aux_func,
    input  logic [2:0] odiv_sel,
    input  logic [8:0] vco_word,
    input  logic [6:0] ref_word,
    output logic       sclk,
    output logic       sdata,
    output logic       strobe,
    output logic       busy,
    output logic       err
);
    clk_rec_t           rec;
    logic [FRAME_W-1:0] frame;
    logic               rec_ok;

    assign rec = '{cap: cap_code, duty: duty_sel, aux: aux_func,
                   odiv: odiv_sel, vco: vco_word, refd: ref_word};

    clkprog_check #(.VCO_MIN(VCO_MIN)) u_check (
        .rec        (rec),
        .bypass_req (bypass_req),
        .frame      (frame),
        .rec_ok     (rec_ok)
    );

    clkprog_seq #(
        .SETUP_CYC (SETUP_CYC),
        .HIGH_CYC  (HIGH_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .GAP_CYC   (GAP_CYC),
        .STB_CYC   (STB_CYC)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .rec_ok (rec_ok),
        .frame  (frame),
        .sclk   (sclk),
        .sdata  (sdata),
        .strobe (strobe),
        .busy   (busy),
        .err    (err)
    );
endmodule

// File: tb/clksynth_prog_master_bench.sv
module clksynth_prog_master_bench;
    localparam int SETUP_CYC = 2;
    localparam int HIGH_CYC  = 2;
    localparam int HOLD_CYC  = 1;
    localparam int GAP_CYC   = 1;
    localparam int STB_CYC   = 4;
    localparam int BUSY_EXP  = 24 * (SETUP_CYC + HIGH_CYC + HOLD_CYC) + GAP_CYC + STB_CYC;
    localparam int NVEC      = 7;

    // {cap, duty, aux, odiv, vco, ref, bypass, ok, expected frame}
    localparam logic [49:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 2'd2, 3'd1, 9'd276, 7'd59,  1'b0, 1'b1, 24'h318A3B},
        {2'd3, 1'b0, 2'd0, 3'd0, 9'd4,   7'd1,   1'b0, 1'b1, 24'hC00201},
        {2'd0, 1'b0, 2'd0, 3'd0, 9'd3,   7'd10,  1'b0, 1'b0, 24'h000000},
        {2'd1, 1'b1, 2'd1, 3'd2, 9'd100, 7'd0,   1'b0, 1'b0, 24'h000000},
        {2'd1, 1'b0, 2'd3, 3'd7, 9'd511, 7'd0,   1'b1, 1'b1, 24'h5FFF80},
        {2'd0, 1'b0, 2'd0, 3'd0, 9'd0,   7'd0,   1'b1, 1'b0, 24'h000000},
        {2'd3, 1'b1, 2'd3, 3'd7, 9'd511, 7'd127, 1'b0, 1'b1, 24'hFFFFFF}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bypass_req = 1'b0;
    logic [1:0] cap_code = '0;
    logic duty_sel = 1'b0;
    logic [1:0] aux_func = '0;
    logic [2:0] odiv_sel = '0;
    logic [8:0] vco_word = '0;
    logic [6:0] ref_word = '0;
    logic sclk, sdata, strobe, busy, err;

    always #5 clk = ~clk;

    clksynth_prog_master u_clksynth_prog_master (
        .clk(clk), .rst_n(rst_n), .start(start), .bypass_req(bypass_req),
        .cap_code(cap_code), .duty_sel(duty_sel), .aux_func(aux_func),
        .odiv_sel(odiv_sel), .vco_word(vco_word), .ref_word(ref_word),
        .sclk(sclk), .sdata(sdata), .strobe(strobe), .busy(busy), .err(err)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Pin monitor, sampled on falling clock edges.
    logic        mon_clr = 1'b0;
    logic [23:0] cap_bits;
    int nbits, nstb, stbw, bcyc, viol, data_age, low_age;
    logic p_sclk, p_data, p_stb;

    always @(negedge clk) begin
        if (mon_clr) begin
            cap_bits = '0; nbits = 0; nstb = 0; stbw = 0; bcyc = 0; viol = 0;
        end else begin
            if (sclk) low_age = 0;
            else if (p_sclk) low_age = 0;
            else low_age++;
            if (sdata != p_data) begin
                if (sclk || low_age < HOLD_CYC) viol++;
                data_age = 0;
            end else data_age++;
            if (sclk && !p_sclk) begin
                if (data_age < SETUP_CYC) viol++;
                if (strobe) viol++;
                cap_bits = {cap_bits[22:0], sdata};
                nbits++;
            end
            if (strobe && !p_stb) begin
                nstb++;
                if (sclk || low_age < HOLD_CYC + GAP_CYC) viol++;
            end
            if (strobe) stbw++;
            if (busy) bcyc++;
        end
        p_sclk = sclk; p_data = sdata; p_stb = strobe;
    end

    initial begin
        cap_bits = '0; nbits = 0; nstb = 0; stbw = 0; bcyc = 0; viol = 0;
        data_age = 100; low_age = 100; p_sclk = 1'b0; p_data = 1'b0; p_stb = 1'b0;
    end

    task automatic chk(input bit good, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!good) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 50000) begin
            chk(1'b0, "watchdog", wd, 50000);
            finish_run();
        end
    end

    task automatic clear_mon();
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic load_rec(input logic [49:0] v);
        cap_code = v[49:48]; duty_sel = v[47]; aux_func = v[46:45];
        odiv_sel = v[44:42]; vco_word = v[41:33]; ref_word = v[32:26];
        bypass_req = v[25];
    endtask

    initial begin
        // R9: reset state, start ignored in reset
        @(negedge clk);
        start = 1'b1;
        load_rec(VEC[0]);
        @(negedge clk);
        chk(!sclk && !sdata && !strobe && !busy && !err, "R9 reset outputs",
            {sclk, sdata, strobe, busy, err}, 0);
        start = 1'b0;
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!sclk && !sdata && !strobe && !busy && !err, "R9 idle outputs",
            {sclk, sdata, strobe, busy, err}, 0);

        // Vector table: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NVEC; i++) begin
            clear_mon();
            load_rec(VEC[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(err == !VEC[i][24], "R5/R6/R7 err after start", err, !VEC[i][24]);
            repeat (BUSY_EXP + 10) @(negedge clk);
            if (VEC[i][24]) begin
                chk(cap_bits == VEC[i][23:0], "R1 frame", cap_bits, VEC[i][23:0]);
                chk(nbits == 24, "R2 sclk rising edges", nbits, 24);
                chk(viol == 0, "R2/R3 setup hold gap", viol, 0);
                chk(nstb == 1 && stbw == STB_CYC, "R3 strobe pulse", {nstb[15:0], stbw[15:0]},
                    {16'd1, 16'(STB_CYC)});
                chk(bcyc == BUSY_EXP, "R4 busy cycles", bcyc, BUSY_EXP);
                chk(!sdata && !sclk, "R9 lines low after transfer", {sdata, sclk}, 0);
            end else begin
                chk(nbits == 0 && nstb == 0 && bcyc == 0, "R5/R6 nothing sent",
                    nbits + nstb + bcyc, 0);
                chk(err, "R7 err held", err, 1);
            end
        end

        // R8: start held across the whole strobe pulse, including its last cycle
        clear_mon();
        load_rec(VEC[0]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        load_rec(VEC[1]);
        while (!strobe) @(negedge clk);
        start = 1'b1;
        repeat (STB_CYC) @(negedge clk);
        start = 1'b0;
        chk(!busy && !strobe, "R8 busy falls with strobe", {busy, strobe}, 0);
        repeat (40) @(negedge clk);
        chk(nbits == 24 && nstb == 1, "R8 start during strobe ignored",
            {nbits[15:0], nstb[15:0]}, {16'd24, 16'd1});
        chk(cap_bits == 24'h318A3B, "R8 first frame intact", cap_bits, 24'h318A3B);

        // R8: start mid-transfer with a refused record must not set err
        clear_mon();
        load_rec(VEC[6]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        load_rec(VEC[2]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (BUSY_EXP) @(negedge clk);
        chk(!err, "R8 err untouched while busy", err, 0);
        chk(cap_bits == 24'hFFFFFF && nbits == 24, "R8 frame unaffected", cap_bits, 24'hFFFFFF);

        finish_run();
    end
endmodule